// File: doc/BRIEF.md
# Programmable Vectored Countdown Timer

This block is a down-counter with a small register file, meant to sit beside an interrupt controller and produce timer interrupts. Software programs a control word (an interrupt vector, a mask flag and a one-shot or repeating mode), a divide setting and a start count. Writing the start count loads the running count and begins the countdown. The count decreases by one each time the divided time base fires, and the time base is a single-cycle tick-enable input.

When the running count reaches zero the block raises a one-cycle interrupt request carrying the programmed vector, unless the mask flag is set. In one-shot mode the count then stays at zero. In repeating mode it reloads from the start count and keeps going. Rewriting the mode while the count is running does not reload or reset anything: counting carries on from the present value under the new mode. A count that has already reached zero is not restarted by a switch to repeating mode. Only a new start-count write restarts it.

Top module: `vec_countdown_timer`

## Requirements
- R1: After reset, all four readable registers read as zero and `irq_req` is low.
- R2: A write to the start-count register (select 1) loads both the start count and the running count in the same clock edge, and restarts the divider phase.
- R3: The divide code is taken from write-data bits {3,1,0}, with bit 3 as the most significant bit. Codes 000 to 110 divide the tick by 2, 4, 8, 16, 32, 64 and 128. Data bit 2 is ignored and reads back as 0. The running count drops by one on every Nth tick after a start-count or divide write.
- R4: The divide value 0xB (code 111) selects divide-by-1, so the count drops on every tick.
- R5: In one-shot mode (control bits 18:17 = 00), the tick that takes the count from 1 to 0 raises `irq_req` for exactly one cycle on the next clock edge, with `irq_vec` equal to control bits 7:0. The count then stays at 0 and no further requests follow.
- R6: In repeating mode (bits 18:17 = 01), that same tick reloads the running count from the start count and raises the request. Counting then continues.
- R7: A control-word write changes neither the start count nor the running count. The countdown continues from its current value under the new mode.
- R8: If the running count is 0, it stays 0 under any mode change, including a switch to repeating mode, until the start count is written.
- R9: When control bit 16 (mask) is set, reaching zero raises no request, but counting behaves as it does unmasked.
- R10: Writing a start count of 0 sets the running count to 0 and stops the timer, and no request is raised.
- R11: Register selects are 0 for control, 1 for start count, 2 for running count and 3 for divide. Writes to select 2 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Time-base tick, one cycle per tick |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | CNT_W | Write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | CNT_W | Combinational read data |
| irq_req | output | 1 | One-cycle interrupt request |
| irq_vec | output | VEC_W | Vector sent with the request |

## Verification
A register write takes effect at the clock edge where `wr_en` is sampled. The running count is visible through `rd_data` in the following cycle, because the read path is combinational. A terminal tick updates the count and raises `irq_req` together, one edge after the tick is sampled. The bench changes inputs only on falling edges and samples on falling edges, so every result is read in the half-cycle after the edge that produced it. The scoreboard queues each expected vector before the ticks that should produce it. A monitor pops the queue on every request it sees. A request with nothing queued, or a queued vector that is never delivered, counts as an error.

// File: rtl/vct_pkg.sv
package vct_pkg;

   typedef enum logic [1:0] {
      SEL_CTRL  = 2'd0,
      SEL_START = 2'd1,
      SEL_RUN   = 2'd2,
      SEL_DIV   = 2'd3
   } reg_sel_e;

   typedef enum logic [1:0] {
      MODE_ONCE   = 2'b00,
      MODE_REPEAT = 2'b01
   } tmode_e;

   localparam int MASK_POS  = 16;
   localparam int MODE_LSB  = 17;
   localparam int MODE_MSB  = 18;
   localparam int SHIFT_W   = 3;
   localparam int MAX_SHIFT = 7;

   // code 111 -> no division, otherwise divide by 2^(code+1)
   function automatic logic [SHIFT_W-1:0] div_shift(input logic [2:0] code);
      return (code == 3'b111) ? 3'd0 : code + 3'd1;
   endfunction

endpackage

// File: rtl/vct_cfg_regs.sv
module vct_cfg_regs
   import vct_pkg::*;
#(
   parameter int CNT_W = 32,
   parameter int VEC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [CNT_W-1:0] wr_data,
   output logic [VEC_W-1:0] vector,
   output logic             masked,
   output logic [1:0]       mode_raw,
   output logic             repeat_mode,
   output logic [2:0]       div_code,
   output logic             div_wr
);

   logic ctrl_wr;

   assign ctrl_wr     = wr_en && (wr_sel == SEL_CTRL);
   assign div_wr      = wr_en && (wr_sel == SEL_DIV);
   assign repeat_mode = (mode_raw == MODE_REPEAT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vector   <= '0;
         masked   <= 1'b0;
         mode_raw <= MODE_ONCE;
      end else if (ctrl_wr) begin
         vector   <= wr_data[VEC_W-1:0];
         masked   <= wr_data[MASK_POS];
         mode_raw <= wr_data[MODE_MSB:MODE_LSB];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_code <= 3'b000;
      end else if (div_wr) begin
         div_code <= {wr_data[3], wr_data[1:0]};
      end
   end

   assert_div_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
      div_wr |=> div_code == {$past(wr_data[3]), $past(wr_data[1:0])});

endmodule

// File: rtl/vct_prescaler.sv
module vct_prescaler
   import vct_pkg::*;
#(
   parameter bit DIV_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_en,
   input  logic       clr,
   input  logic [2:0] div_code,
   output logic       step
);

   localparam int PRE_W = MAX_SHIFT;

   generate
      if (DIV_EN) begin : g_div
         logic [PRE_W-1:0]   pre;
         logic [PRE_W-1:0]   lim;
         logic [SHIFT_W-1:0] shamt;

         assign shamt = div_shift(div_code);
         assign lim   = ~({PRE_W{1'b1}} << shamt);
         assign step  = tick_en && (pre == lim);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pre <= '0;
            end else if (clr) begin
               pre <= '0;
            end else if (tick_en) begin
               pre <= step ? '0 : pre + 1'b1;
            end
         end

         assert_pre_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
            pre <= lim);
         assert_step_needs_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
            step |-> tick_en);
      end else begin : g_nodiv
         assign step = tick_en;
      end
   endgenerate

endmodule

// File: rtl/vct_down_counter.sv
module vct_down_counter #(
   parameter int CNT_W = 32,
   parameter int VEC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             step,
   input  logic             repeat_mode,
   input  logic             masked,
   input  logic [VEC_W-1:0] vector,
   output logic [CNT_W-1:0] run_cnt,
   output logic [CNT_W-1:0] start_cnt,
   output logic             irq_req,
   output logic [VEC_W-1:0] irq_vec
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic terminal;

   assign terminal = step && (run_cnt == ONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_cnt   <= '0;
         start_cnt <= '0;
         irq_req   <= 1'b0;
         irq_vec   <= '0;
      end else begin
         irq_req <= 1'b0;
         if (load) begin
            start_cnt <= load_val;
            run_cnt   <= load_val;
         end else if (step && run_cnt != '0) begin
            if (terminal) begin
               run_cnt <= repeat_mode ? start_cnt : '0;
               irq_req <= !masked;
               if (!masked) irq_vec <= vector;
            end else begin
               run_cnt <= run_cnt - ONE;
            end
         end
      end
   end

   assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> run_cnt == $past(load_val) && start_cnt == $past(load_val));
   assert_irq_from_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> $past(run_cnt) == ONE);
   assert_once_stays_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && !$past(repeat_mode)) |-> run_cnt == '0);
   assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && $past(repeat_mode)) |-> run_cnt == $past(start_cnt));
   assert_zero_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (run_cnt == '0 && !load) |=> run_cnt == '0);
   assert_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> !$past(masked));
   assert_irq_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |=> !irq_req || $past(run_cnt) == ONE);

endmodule

// File: rtl/vec_countdown_timer.sv
module vec_countdown_timer
   import vct_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int VEC_W  = 8,
   parameter bit DIV_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [CNT_W-1:0] wr_data,
   input  logic [1:0]       rd_sel,
   output logic [CNT_W-1:0] rd_data,
   output logic             irq_req,
   output logic [VEC_W-1:0] irq_vec
);

   generate
      if (CNT_W < MODE_MSB + 1) begin : g_bad_cnt
         $error("CNT_W must hold the control word");
      end
      if (VEC_W < 1 || VEC_W > MASK_POS) begin : g_bad_vec
         $error("VEC_W must lie below the mask bit");
      end
   endgenerate

   logic [VEC_W-1:0] vector;
   logic             masked;
   logic [1:0]       mode_raw;
   logic             repeat_mode;
   logic [2:0]       div_code;
   logic             div_wr;
   logic             load;
   logic             step;
   logic [CNT_W-1:0] run_cnt;
   logic [CNT_W-1:0] start_cnt;
   logic [CNT_W-1:0] ctrl_word;
   logic [CNT_W-1:0] div_word;

   assign load = wr_en && (wr_sel == SEL_START);

   vct_cfg_regs #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_cfg (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_sel      (wr_sel),
      .wr_data     (wr_data),
      .vector      (vector),
      .masked      (masked),
      .mode_raw    (mode_raw),
      .repeat_mode (repeat_mode),
      .div_code    (div_code),
      .div_wr      (div_wr)
   );

   vct_prescaler #(.DIV_EN(DIV_EN)) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_en  (tick_en),
      .clr      (load || div_wr),
      .div_code (div_code),
      .step     (step)
   );

   vct_down_counter #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .load        (load),
      .load_val    (wr_data),
      .step        (step),
      .repeat_mode (repeat_mode),
      .masked      (masked),
      .vector      (vector),
      .run_cnt     (run_cnt),
      .start_cnt   (start_cnt),
      .irq_req     (irq_req),
      .irq_vec     (irq_vec)
   );

   always_comb begin
      ctrl_word                    = '0;
      ctrl_word[VEC_W-1:0]         = vector;
      ctrl_word[MASK_POS]          = masked;
      ctrl_word[MODE_MSB:MODE_LSB] = mode_raw;
      div_word                     = '0;
      div_word[3]                  = div_code[2];
      div_word[1:0]                = div_code[1:0];
   end

   always_comb begin
      case (rd_sel)
         SEL_CTRL:  rd_data = ctrl_word;
         SEL_START: rd_data = start_cnt;
         SEL_RUN:   rd_data = run_cnt;
         default:   rd_data = div_word;
      endcase
   end

   assert_mode_write_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_CTRL && !step) |=>
         run_cnt == $past(run_cnt) && start_cnt == $past(start_cnt));
   assert_run_write_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_RUN && !step) |=> run_cnt == $past(run_cnt));

endmodule

// File: tb/vec_countdown_timer_bench.sv
`timescale 1ns/1ps
module vec_countdown_timer_bench;

   typedef struct {
      logic [7:0] vec;
      string      tag;
   } exp_item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'd0;
   logic [31:0] wr_data = '0;
   logic [1:0]  rd_sel = 2'd0;
   logic [31:0] rd_data;
   logic        irq_req;
   logic [7:0]  irq_vec;

   int checks = 0;
   int errors = 0;
   int irq_seen = 0;
   exp_item_t expq[$];

   always #2 clk = ~clk;

   vec_countdown_timer u_vec_countdown_timer (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
      .rd_data(rd_data), .irq_req(irq_req), .irq_vec(irq_vec));

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] sel, logic [31:0] data);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic ticks(int n);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
   endtask

   task automatic rd(string tag, logic [1:0] sel, logic [31:0] exp);
      rd_sel = sel;
      #0.5;
      check(tag, rd_data, exp);
   endtask

   task automatic expect_irq(logic [7:0] v, string tag);
      exp_item_t it;
      it.vec = v; it.tag = tag;
      expq.push_back(it);
   endtask

   // monitor: pops scoreboard on every request
   always @(negedge clk) begin
      if (rst_n && irq_req) begin
         irq_seen++;
         if (expq.size() == 0) begin
            checks++; errors++;
            $display("FAIL R9/R10 unexpected request: actual vec=0x%0h expected none", irq_vec);
         end else begin
            exp_item_t it;
            it = expq.pop_front();
            check(it.tag, {24'd0, irq_vec}, {24'd0, it.vec});
         end
      end
   end

   initial begin
      #(4 * 100000);
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd("R1 ctrl", 2'd0, 32'h0);
      rd("R1 start", 2'd1, 32'h0);
      rd("R1 run", 2'd2, 32'h0);
      rd("R1 div", 2'd3, 32'h0);
      check("R1 irq_req", {31'd0, irq_req}, 32'd0);
      // R11 running count not writable
      wr(2'd2, 32'h55);
      rd("R11 run write ignored", 2'd2, 32'h0);
      // R4 divide-by-1, R5 one-shot
      wr(2'd3, 32'hB);
      rd("R4 div readback", 2'd3, 32'hB);
      wr(2'd0, 32'h31);
      rd("R11 ctrl readback", 2'd0, 32'h31);
      wr(2'd1, 32'd5);
      rd("R2 run loaded", 2'd2, 32'd5);
      rd("R2 start loaded", 2'd1, 32'd5);
      ticks(3);
      rd("R4 one per tick", 2'd2, 32'd2);
      expect_irq(8'h31, "R5 one-shot vector");
      ticks(2);
      rd("R5 at zero", 2'd2, 32'd0);
      check("R5 one request", irq_seen, 1);
      ticks(3);
      rd("R5 stays zero", 2'd2, 32'd0);
      check("R5 no repeat", irq_seen, 1);
      // R6 repeating
      wr(2'd0, 32'h0002_0042);
      wr(2'd1, 32'd4);
      expect_irq(8'h42, "R6 first period");
      ticks(4);
      rd("R6 reload", 2'd2, 32'd4);
      check("R6 first request", irq_seen, 2);
      ticks(1);
      rd("R6 keeps counting", 2'd2, 32'd3);
      expect_irq(8'h42, "R6 second period");
      ticks(3);
      rd("R6 second reload", 2'd2, 32'd4);
      check("R6 second request", irq_seen, 3);
      // R7 mode change mid-count
      wr(2'd1, 32'd10);
      ticks(3);
      rd("R7 before switch", 2'd2, 32'd7);
      wr(2'd0, 32'h42);
      rd("R7 run kept", 2'd2, 32'd7);
      rd("R7 start kept", 2'd1, 32'd10);
      expect_irq(8'h42, "R7 one-shot after switch");
      ticks(7);
      rd("R7 ended at zero", 2'd2, 32'd0);
      check("R7 request", irq_seen, 4);
      // R8 zero not restarted by repeating mode
      wr(2'd0, 32'h0002_0042);
      rd("R8 still zero", 2'd2, 32'd0);
      ticks(5);
      rd("R8 zero after ticks", 2'd2, 32'd0);
      check("R8 no request", irq_seen, 4);
      // R9 mask
      wr(2'd0, 32'h0001_0077);
      rd("R9 ctrl readback", 2'd0, 32'h0001_0077);
      wr(2'd1, 32'd3);
      ticks(2);
      rd("R9 counts while masked", 2'd2, 32'd1);
      ticks(1);
      rd("R9 reaches zero", 2'd2, 32'd0);
      check("R9 no request", irq_seen, 4);
      // R10 start count zero stops
      wr(2'd0, 32'h55);
      wr(2'd1, 32'd6);
      ticks(2);
      rd("R10 running", 2'd2, 32'd4);
      wr(2'd1, 32'd0);
      rd("R10 stopped", 2'd2, 32'd0);
      ticks(10);
      rd("R10 stays stopped", 2'd2, 32'd0);
      check("R10 no request", irq_seen, 4);
      // R3 divide codes
      wr(2'd3, 32'h0);
      wr(2'd1, 32'd3);
      ticks(4);
      rd("R3 div2", 2'd2, 32'd1);
      expect_irq(8'h55, "R3 div2 request");
      ticks(2);
      rd("R3 div2 zero", 2'd2, 32'd0);
      check("R3 div2 request", irq_seen, 5);
      wr(2'd3, 32'h5);
      rd("R3 bit2 ignored", 2'd3, 32'h1);
      wr(2'd1, 32'd10);
      ticks(8);
      rd("R3 div4", 2'd2, 32'd8);
      wr(2'd3, 32'hA);
      wr(2'd1, 32'd2);
      ticks(127);
      rd("R3 div128 not yet", 2'd2, 32'd2);
      ticks(1);
      rd("R3 div128 step", 2'd2, 32'd1);
      repeat (3) @(negedge clk);
      check("R5 all expected requests seen", expq.size(), 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule